// File: doc/BRIEF.md
# Halt-Mode Wakeup Startup Sequencer

This block controls a deep low-power halt of a small processor core. A software write requests the halt. The sequencer then raises the halt flag and removes both the oscillator enable and the core clock enable. While halted, it watches for exit events:

- a wakeup event from the port wakeup logic;
- in RC clock mode only, a rising edge on the clock-output pin;
- the asynchronous active-low reset.

When a valid event arrives, the sequencer first re-enables only the oscillator. It then waits out a stabilisation delay of 256 instruction cycles, where one instruction cycle is `DIV` (default 10) oscillator cycles. Only after that delay does it hand the clocks back to the core. In crystal mode the delay is always applied. In RC mode a configuration bit chooses whether the delay is applied, and that bit resets to 0.

A strap can forbid halting altogether. While it does, halt requests are ignored.

The state machine has three states:

- **RUN**: clocks on, flag clear.
- **HALT**: oscillator and core clocks off, flag set.
- **WARM**: oscillator on, core clock off, flag set.

Its transitions are:

- *enter-halt*: RUN to HALT.
- *warm-start*: HALT to WARM, on a valid wake when a delay is needed.
- *direct-wake*: HALT to RUN, on a valid wake with no delay.
- *warm-done*: WARM to RUN, when the delay counter expires.
- *reset*: any state to RUN, asynchronously.

Top module: `halt_wake_seq`

## Requirements
- R1: While `rst_n` is low, the block is in RUN with `osc_en`=1, `core_clk_en`=1 and `halt_flag`=0, whatever state it was in before; this takes effect immediately, without waiting for a clock edge.
- R2: With `halt_allow`=1, a `halt_req` pulse in RUN causes, at the next rising clock edge, `halt_flag`=1, `osc_en`=0 and `core_clk_en`=0.
- R3: With `halt_allow`=0, a `halt_req` pulse has no effect: `halt_flag` stays 0 and both enables stay 1.
- R4: A wake event (a `wake_evt` pulse, or a valid rising edge on `clkout_pin`) seen in HALT changes the outputs at the third rising clock edge after it is driven. The first two edges are for the two synchroniser flops and the third is the state change.
- R5: In crystal mode (`xtal_mode`=1), a wake enters WARM with `osc_en`=1, `core_clk_en`=0 and `halt_flag`=1. Exactly 256*DIV = 2560 clock edges later, the block returns to RUN with `core_clk_en`=1 and `halt_flag`=0.
- R6: In RC mode (`xtal_mode`=0) with the delay bit at 0, a wake goes directly from HALT to RUN, with no WARM phase.
- R7: In RC mode with the delay bit at 1, a wake goes through WARM for 2560 clock edges, the same as in R5.
- R8: In crystal mode, a rising edge on `clkout_pin` has no effect while halted; the block stays in HALT.
- R9: The delay bit is written through `cfg_dly_wr`/`cfg_dly_val` and reads as 0 after reset, so an RC-mode wake after reset exits without delay.
- R10: A `wake_evt` pulse while in RUN has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; this is also the third exit path |
| halt_req | input | 1 | One-cycle pulse from the software write of 1 to the halt flag |
| wake_evt | input | 1 | Wake event from the port wakeup logic; asynchronous |
| clkout_pin | input | 1 | Level of the clock-output pin; asynchronous |
| xtal_mode | input | 1 | Clock-mode strap: 1 = crystal/resonator, 0 = RC |
| halt_allow | input | 1 | Mask strap: 1 = halt permitted, 0 = halt disabled |
| cfg_dly_wr | input | 1 | Write strobe for the RC-mode delay bit |
| cfg_dly_val | input | 1 | Value written to the delay bit |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Enable that routes clocks to the rest of the core |
| halt_flag | output | 1 | Halt flag as software sees it |

## Verification
The outputs are decoded directly from the state register, so each result has a fixed latency. A halt request shows at the first rising edge. A wake or pin edge shows at the third rising edge. A warm-up ends exactly 2560 edges after WARM is entered. Reset acts with no edge at all. The bench drives every input on a falling edge and samples on falling edges. For each timed result it checks the sample just before the due edge, where the old value must still hold, and the sample just after it, where the new value must appear. The reset checks sample a fraction of a nanosecond after `rst_n` falls, in the middle of a cycle.

// File: rtl/hws_pkg.sv
package hws_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_HALT = 2'd1,
        ST_WARM = 2'd2
    } hws_state_e;
endpackage

// File: rtl/hws_sync.sv
module hws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hws_tick_div.sv
module hws_tick_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       phase_q <= '0;
        else if (clr)     phase_q <= '0;
        else if (run)     phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    assign tick = run && (phase_q == LAST);

    // R5: while running, the phase never leaves its legal range
    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase_q <= LAST));
endmodule

// File: rtl/hws_dly_cnt.sv
module hws_dly_cnt #(
    parameter int DLY_INIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic expire
);
    localparam int CNT_W = $clog2(DLY_INIT + 1);
    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(DLY_INIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= INIT_V;
        else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expire = tick && (cnt_q == CNT_W'(1));

    // R5: each instruction tick removes exactly one count
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R7: a fresh load always starts from the full preload
    assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == INIT_V));
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq
    import hws_pkg::*;
#(
    parameter int DIV         = 10,
    parameter int DLY_INIT    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic wake_evt,
    input  logic clkout_pin,
    input  logic xtal_mode,
    input  logic halt_allow,
    input  logic cfg_dly_wr,
    input  logic cfg_dly_val,
    output logic osc_en,
    output logic core_clk_en,
    output logic halt_flag
);
    hws_state_e st_q, st_d;
    logic       wake_s, pin_s, pin_prev_q, pin_rise;
    logic       dly_en_q, need_dly, wake_ok;
    logic       warm_load, tick, expire;

    hws_sync #(.STAGES(SYNC_STAGES)) u_wake_sync (
        .clk(osc_clk), .rst_n(rst_n), .d_async(wake_evt), .q_sync(wake_s));

    hws_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(osc_clk), .rst_n(rst_n), .d_async(clkout_pin), .q_sync(pin_s));

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) pin_prev_q <= 1'b0;
        else        pin_prev_q <= pin_s;
    end
    assign pin_rise = pin_s && !pin_prev_q;

    // RC-mode delay configuration bit
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n)          dly_en_q <= 1'b0;
        else if (cfg_dly_wr) dly_en_q <= cfg_dly_val;
    end

    assign wake_ok   = wake_s || (pin_rise && !xtal_mode);
    assign need_dly  = xtal_mode || dly_en_q;
    assign warm_load = (st_q == ST_HALT) && wake_ok && need_dly;

    hws_tick_div #(.DIV(DIV)) u_div (
        .clk(osc_clk), .rst_n(rst_n), .clr(warm_load),
        .run(st_q == ST_WARM), .tick(tick));

    hws_dly_cnt #(.DLY_INIT(DLY_INIT)) u_cnt (
        .clk(osc_clk), .rst_n(rst_n), .load(warm_load),
        .tick(tick), .expire(expire));

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (halt_req && halt_allow) st_d = ST_HALT;
            ST_HALT: if (wake_ok)                st_d = need_dly ? ST_WARM : ST_RUN;
            ST_WARM: if (expire)                 st_d = ST_RUN;
            default:                             st_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        osc_en      = 1'b1;
        core_clk_en = 1'b1;
        halt_flag   = 1'b0;
        unique case (st_q)
            ST_RUN:  ;
            ST_HALT: begin osc_en = 1'b0; core_clk_en = 1'b0; halt_flag = 1'b1; end
            ST_WARM: begin core_clk_en = 1'b0; halt_flag = 1'b1; end
            default: ;
        endcase
    end

    assert_halt_entry_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (st_q == ST_RUN && halt_req && halt_allow) |=> (halt_flag && !osc_en && !core_clk_en));

    assert_flag_stuck_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (st_q == ST_RUN && !halt_allow) |=> !halt_flag);

    assert_core_gated_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> ($past(st_q) == ST_WARM ||
                                ($past(st_q) == ST_HALT && !$past(need_dly))));

    assert_no_skip_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (st_q == ST_HALT && wake_ok && !need_dly) |=> (core_clk_en && osc_en));

    assert_xtal_pin_R8: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (st_q == ST_HALT && xtal_mode && !wake_s) |=> (st_q == ST_HALT));

    assert_run_wake_R10: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (st_q == ST_RUN && !halt_req) |=> (core_clk_en && !halt_flag));
endmodule

// File: tb/tb_halt_wake_seq.sv
module tb_halt_wake_seq;
    localparam int WARM_CYC = 2560;

    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 1'b0, wake_evt = 1'b0, clkout_pin = 1'b0;
    logic xtal_mode = 1'b1, halt_allow = 1'b1;
    logic cfg_dly_wr = 1'b0, cfg_dly_val = 1'b0;
    logic osc_en, core_clk_en, halt_flag;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2 osc_clk = ~osc_clk;

    halt_wake_seq dut (
        .osc_clk(osc_clk), .rst_n(rst_n), .halt_req(halt_req), .wake_evt(wake_evt),
        .clkout_pin(clkout_pin), .xtal_mode(xtal_mode), .halt_allow(halt_allow),
        .cfg_dly_wr(cfg_dly_wr), .cfg_dly_val(cfg_dly_val),
        .osc_en(osc_en), .core_clk_en(core_clk_en), .halt_flag(halt_flag));

    task automatic step(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    // expected = {osc_en, core_clk_en, halt_flag}
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {osc_en, core_clk_en, halt_flag};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {osc,core,flag} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_halt();
        halt_req = 1'b1; step(1); halt_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset held", 3'b110);
        step(2); rst_n = 1'b1; step(2);
        chk("R1 after release", 3'b110);
    endtask

    task automatic t_halt_entry();
        do_halt();
        chk("R2 halt entry", 3'b001);
    endtask

    task automatic t_xtal_wake();
        xtal_mode = 1'b1;
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
        step(1);
        chk("R4 before third edge", 3'b001);
        step(1);
        chk("R5 warm entered", 3'b101);
        step(WARM_CYC - 1);
        chk("R5 still warming", 3'b101);
        step(1);
        chk("R5 warm done", 3'b110);
    endtask

    task automatic t_halt_disabled();
        halt_allow = 1'b0;
        do_halt();
        chk("R3 request ignored", 3'b110);
        step(3);
        chk("R3 flag stays 0", 3'b110);
        halt_allow = 1'b1;
    endtask

    task automatic t_run_wake();
        pulse_wake();
        step(4);
        chk("R10 wake in run", 3'b110);
    endtask

    task automatic t_rc_direct();
        xtal_mode = 1'b0;
        clkout_pin = 1'b0; step(4);
        do_halt();
        chk("R2 halt in RC", 3'b001);
        clkout_pin = 1'b1; step(2);
        chk("R4 pin before third edge", 3'b001);
        step(1);
        chk("R6 direct wake", 3'b110);
        clkout_pin = 1'b0; step(4);
    endtask

    task automatic t_rc_delay();
        xtal_mode = 1'b0;
        cfg_dly_val = 1'b1; cfg_dly_wr = 1'b1; step(1); cfg_dly_wr = 1'b0; cfg_dly_val = 1'b0;
        do_halt();
        pulse_wake(); step(2);
        chk("R7 warm in RC", 3'b101);
        step(WARM_CYC - 1);
        chk("R7 still warming", 3'b101);
        step(1);
        chk("R7 warm done", 3'b110);
    endtask

    task automatic t_xtal_pin();
        xtal_mode = 1'b1;
        clkout_pin = 1'b0; step(4);
        do_halt();
        clkout_pin = 1'b1; step(10);
        chk("R8 pin ignored in crystal", 3'b001);
        clkout_pin = 1'b0;
        pulse_wake(); step(2 + WARM_CYC);
        chk("R8 exit by wake", 3'b110);
    endtask

    task automatic t_reset_exit();
        xtal_mode = 1'b0;
        cfg_dly_val = 1'b1; cfg_dly_wr = 1'b1; step(1); cfg_dly_wr = 1'b0; cfg_dly_val = 1'b0;
        do_halt();
        pulse_wake(); step(20);
        chk("R7 warming before reset", 3'b101);
        #1 rst_n = 1'b0; #0.5;
        chk("R1 async reset from warm", 3'b110);
        step(2); rst_n = 1'b1; step(3);
        do_halt();
        clkout_pin = 1'b1; step(3);
        chk("R9 delay bit cleared by reset", 3'b110);
        clkout_pin = 1'b0; step(4);
        do_halt();
        #1 rst_n = 1'b0; #0.5;
        chk("R1 async reset from halt", 3'b110);
        step(2); rst_n = 1'b1; step(2);
    endtask

    initial begin
        step(1);
        t_reset();
        t_halt_entry();
        t_xtal_wake();
        t_halt_disabled();
        t_run_wake();
        t_rc_direct();
        t_rc_delay();
        t_xtal_pin();
        t_reset_exit();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule